// File: doc/BRIEF.md
# Fractional UART Baud Rate Generator

This block turns one bus clock into the two timing strobes that a UART transmitter and receiver need. One strobe marks each oversample point and the other marks each bit boundary. The rate comes from three chained stages.

- **Fractional prescaler.** It divides the bus clock by (256+MULT)/256 and has a resolution of 1/256.
- **Integer divider.** It lets one oversample tick through for every BRG+1 prescaler enables.
- **Oversample counter.** It lets one bit tick through for every OSR+1 oversample ticks.

The fractional prescaler is a phase accumulator. It gives the exact average ratio over a long run and never drifts.

To use the block, software places the three values on the configuration inputs and pulses a load strobe for one cycle. On that strobe the block captures the values and restarts its counters. Between strobes the configuration inputs are ignored. An OSR value that is too small to be a useful oversample ratio is raised to the lowest valid value.

Top module: `frac_baud_gen`

## Requirements
- R1: While `rst_n` is low, `os_tick` and `bit_tick` are both low. After reset the block runs with MULT=0, OSR=15 and BRG=0. With those values `os_tick` is high in every cycle and `bit_tick` is high once every 16 cycles.
- R2: The prescaler adds 256 to a phase accumulator in each bus cycle. Whenever the sum reaches 256+MULT, it subtracts 256+MULT and issues an enable. Counting from cycle 1, the n-th enable falls in cycle ceil(n·(256+MULT)/256). Cycle 1 is the first clock edge after the load edge, or the first edge after reset is released.
- R3: `os_tick` is a registered pulse. It is high in the period that follows edge c exactly when c = ceil(k·(BRG+1)·(256+MULT)/256) for some integer k ≥ 1.
- R4: `bit_tick` is a registered pulse. It is high in the period that follows edge c exactly when c = ceil(k·(OSR+1)·(BRG+1)·(256+MULT)/256) for some k ≥ 1. It is never high unless `os_tick` is also high.
- R5: An OSR value of 0 to 3 on a load behaves as OSR=4.
- R6: `cfg_mult`, `cfg_osr` and `cfg_brg` are sampled only on a clock edge where `cfg_load` is high. Changes at any other time have no effect on either output.
- R7: A load edge clears the accumulator and both counters. Both outputs are low in the period that follows the load edge, and counting restarts at cycle 1.
- R8: Over any window of W cycles that starts at an origin, the number of `os_tick` pulses equals floor(256·W / ((256+MULT)·(BRG+1))). The fractional error therefore does not accumulate.
- R9: The phase accumulator always holds a value below 256+MULT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_load | input | 1 | Captures the configuration and restarts all counters |
| cfg_mult | input | 8 | Fractional prescaler numerator extension, 0 to 255 |
| cfg_osr | input | 4 | Oversample ratio minus one; values below 4 are raised to 4 |
| cfg_brg | input | 16 | Integer divider minus one, 0 to 65535 |
| os_tick | output | 1 | One-cycle oversample strobe |
| bit_tick | output | 1 | One-cycle bit-boundary strobe |

## Verification
The hardest behaviour to reach from the ports is the exact placement of each tick when the fractional prescaler skips a cycle partway through a BRG or OSR count. A wrong remainder in the accumulator shows up only as a single displaced pulse many cycles later. The bench therefore drives seeded random MULT values with small BRG and OSR, so that many skips occur inside short windows. It compares every cycle against a closed-form count of floor(256·c/P). It also scrambles the configuration inputs on every cycle between loads. A long window at a half-step MULT checks that the total tick count stays exact.

// File: rtl/fbg_pkg.sv
package fbg_pkg;

  // Smallest OSR setting accepted as an operating point.
  localparam int unsigned FBG_OSR_MIN = 4;

  // Raise a value to a floor.
  function automatic int unsigned fbg_clamp(input int unsigned v, input int unsigned lo);
    return (v < lo) ? lo : v;
  endfunction

  // Accumulator threshold: one full step plus the fractional extension.
  function automatic int unsigned fbg_limit(input int unsigned mult, input int unsigned step);
    return step + mult;
  endfunction

endpackage

// File: rtl/fbg_cfg_regs.sv
module fbg_cfg_regs
  import fbg_pkg::*;
#(
  parameter int MULT_W = 8,
  parameter int OSR_W  = 4,
  parameter int BRG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MULT_W-1:0] mult_in,
  input  logic [OSR_W-1:0]  osr_in,
  input  logic [BRG_W-1:0]  brg_in,
  output logic [MULT_W-1:0] mult_q,
  output logic [OSR_W-1:0]  osr_q,
  output logic [BRG_W-1:0]  brg_q
);

  localparam logic [OSR_W-1:0] OSR_RST = '1;

  logic [OSR_W-1:0] osr_fix;
  assign osr_fix = OSR_W'(fbg_clamp(int'(osr_in), FBG_OSR_MIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q <= '0;
      osr_q  <= OSR_RST;
      brg_q  <= '0;
    end else if (load) begin
      mult_q <= mult_in;
      osr_q  <= osr_fix;
      brg_q  <= brg_in;
    end
  end

endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc
  import fbg_pkg::*;
#(
  parameter int MULT_W = 8,
  localparam int ACC_W = MULT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [MULT_W-1:0] mult,
  output logic              pre_en,
  output logic [ACC_W-1:0]  acc_q,
  output logic [ACC_W-1:0]  acc_lim
);

  localparam int unsigned STEP = 1 << MULT_W;

  logic [ACC_W-1:0] sum;

  assign acc_lim = ACC_W'(fbg_limit(int'(mult), STEP));
  assign sum     = acc_q + ACC_W'(STEP);
  assign pre_en  = !clr && (sum >= acc_lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clr) begin
      acc_q <= '0;
    end else if (pre_en) begin
      acc_q <= sum - acc_lim;
    end else begin
      acc_q <= sum;
    end
  end

endmodule

// File: rtl/fbg_tick_div.sv
module fbg_tick_div #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] last,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  assign wrap = en && (cnt_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int MULT_W = 8,
  parameter int OSR_W  = 4,
  parameter int BRG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [MULT_W-1:0] cfg_mult,
  input  logic [OSR_W-1:0]  cfg_osr,
  input  logic [BRG_W-1:0]  cfg_brg,
  output logic              os_tick,
  output logic              bit_tick
);

  localparam int ACC_W = MULT_W + 2;

  logic [MULT_W-1:0] mult_q;
  logic [OSR_W-1:0]  osr_q;
  logic [BRG_W-1:0]  brg_q;
  logic              pre_en;
  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_lim;
  logic              os_evt;
  logic              bit_evt;

  fbg_cfg_regs #(.MULT_W(MULT_W), .OSR_W(OSR_W), .BRG_W(BRG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .load(cfg_load),
    .mult_in(cfg_mult), .osr_in(cfg_osr), .brg_in(cfg_brg),
    .mult_q(mult_q), .osr_q(osr_q), .brg_q(brg_q)
  );

  fbg_phase_acc #(.MULT_W(MULT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .mult(mult_q),
    .pre_en(pre_en), .acc_q(acc_q), .acc_lim(acc_lim)
  );

  fbg_tick_div #(.CNT_W(BRG_W)) u_brg_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .en(pre_en),
    .last(brg_q), .wrap(os_evt)
  );

  fbg_tick_div #(.CNT_W(OSR_W)) u_osr_div (
    .clk(clk), .rst_n(rst_n), .clr(cfg_load), .en(os_evt),
    .last(osr_q), .wrap(bit_evt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_tick  <= 1'b0;
      bit_tick <= 1'b0;
    end else begin
      os_tick  <= os_evt;
      bit_tick <= bit_evt;
    end
  end

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
  parameter int MULT_W = 8,
  parameter int OSR_W  = 4,
  parameter int BRG_W  = 16,
  localparam int ACC_W = MULT_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_load,
  input logic              pre_en,
  input logic [ACC_W-1:0]  acc_q,
  input logic [ACC_W-1:0]  acc_lim,
  input logic [MULT_W-1:0] mult_q,
  input logic [OSR_W-1:0]  osr_q,
  input logic [BRG_W-1:0]  brg_q,
  input logic              os_tick,
  input logic              bit_tick
);

  p_acc_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < acc_lim);

  p_bit_with_os_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> os_tick);

  p_quiet_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (!os_tick && !bit_tick));

  p_cfg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> ($stable(mult_q) && $stable(osr_q) && $stable(brg_q)));

  p_osr_floor_r5: assert property (@(posedge clk) disable iff (!rst_n)
    osr_q >= OSR_W'(4));

  p_os_needs_pre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_en |=> !os_tick);

endmodule

bind frac_baud_gen frac_baud_chk #(.MULT_W(MULT_W), .OSR_W(OSR_W), .BRG_W(BRG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .pre_en(pre_en),
  .acc_q(acc_q), .acc_lim(acc_lim), .mult_q(mult_q), .osr_q(osr_q),
  .brg_q(brg_q), .os_tick(os_tick), .bit_tick(bit_tick)
);

// File: tb/test_frac_baud_gen.sv
`timescale 1ns/1ps
module test_frac_baud_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [7:0]  cfg_mult = '0;
  logic [3:0]  cfg_osr = '0;
  logic [15:0] cfg_brg = '0;
  logic        os_tick, bit_tick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen i_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mult(cfg_mult),
    .cfg_osr(cfg_osr), .cfg_brg(cfg_brg), .os_tick(os_tick), .bit_tick(bit_tick)
  );

  // Pulses issued by cycle c for a period of p/256 cycles.
  function automatic longint unsigned pulses_by(input longint unsigned c, input longint unsigned p);
    return (256 * c) / p;
  endfunction

  function automatic int unsigned eff_osr(input int unsigned o);
    return (o < 4) ? 4 : o;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic scramble();
    cfg_mult = 8'($urandom);
    cfg_osr  = 4'($urandom);
    cfg_brg  = 16'($urandom);
  endtask

  // Load a configuration; the sample right after the load edge must be quiet (R7).
  task automatic do_load(input int m, input int o, input int b);
    @(negedge clk);
    cfg_mult = 8'(m); cfg_osr = 4'(o); cfg_brg = 16'(b); cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    chk(!os_tick && !bit_tick, "R7 quiet after load", {os_tick, bit_tick}, 0);
  endtask

  // Compare every cycle from the origin against the closed-form schedule (R2, R3, R4, R6, R8).
  task automatic run_window(input int m, input int o, input int b, input int w, input string tag);
    longint unsigned p_os  = longint'(256 + m) * longint'(b + 1);
    longint unsigned p_bit = p_os * longint'(eff_osr(o) + 1);
    longint unsigned n_os = 0;
    for (int c = 1; c <= w; c++) begin
      bit e_os, e_bit;
      @(negedge clk);
      e_os  = pulses_by(c, p_os)  != pulses_by(c - 1, p_os);
      e_bit = pulses_by(c, p_bit) != pulses_by(c - 1, p_bit);
      chk(os_tick == e_os,   {tag, " R3 os_tick"},  os_tick,  e_os);
      chk(bit_tick == e_bit, {tag, " R4 bit_tick"}, bit_tick, e_bit);
      if (os_tick) n_os++;
      scramble(); // R6: unloaded inputs must not matter
    end
    chk(n_os == pulses_by(w, p_os), {tag, " R8 tick total"}, n_os, pulses_by(w, p_os));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    scramble();
    // R1: outputs low through reset
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(!os_tick && !bit_tick, "R1 reset quiet", {os_tick, bit_tick}, 0);
    end
    rst_n = 1'b1;
    run_window(0, 15, 0, 80, "R1 defaults");
    // R2: BRG=0 exposes the prescaler directly
    do_load(255, 15, 0);
    run_window(255, 15, 0, 300, "R2 max mult");
    do_load(1, 4, 0);
    run_window(1, 4, 0, 600, "R2 tiny fraction");
    // R5: OSR below 4 acts as 4
    do_load(0, 0, 0);
    run_window(0, 0, 0, 100, "R5 osr0");
    do_load(37, 3, 1);
    run_window(37, 3, 1, 300, "R5 osr3");
    // R8: long run at half step
    do_load(128, 7, 2);
    run_window(128, 7, 2, 6000, "R8 long");
    // Largest division: no ticks inside a short window
    do_load(255, 15, 65535);
    run_window(255, 15, 65535, 400, "R3 max div");
    // R7: reload mid-count restarts
    do_load(10, 4, 3);
    run_window(10, 4, 3, 57, "R7 part");
    do_load(10, 4, 3);
    run_window(10, 4, 3, 300, "R7 restart");
    // Random configurations
    for (int i = 0; i < 30; i++) begin
      int m = $urandom_range(0, 255);
      int o = $urandom_range(0, 15);
      int b = $urandom_range(0, 5);
      do_load(m, o, b);
      run_window(m, o, b, 350, "R2 random");
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule